// File: doc/BRIEF.md
# Waveform Playback Trigger Controller

This block decides when a stored chip sequence is played back. It runs on the chip clock, so one clock cycle is one chip. It has two outputs for the playback side. `play_en` lets the sequence address counter advance. A one-cycle `restart` pulse sends that counter back to the first chip. A third output, `trig_out`, pulses in the same cycle in which a trigger is accepted.

Triggers come from two sources. One is an external line, which passes through a two-flop synchronizer; a polarity bit picks the edge that counts. The other is a manual strobe. A mode input selects one of four playback modes. Free-running mode ignores all triggers. Two modes restart the sequence on each accepted trigger. Two armed modes keep the output idle until the first trigger arrives. A programmable delay, counted in chips, sets how long after a trigger playback starts. A programmable inhibit window, also counted in chips, locks out retriggers after each accepted trigger.

Top module: `playback_trigger_ctrl`

## Requirements
- R1: Reset state. In modes 0 and 1, `restart` and `play_en` both go high in the first cycle after the first clock edge that follows reset release. `restart` then falls the next cycle, and `play_en` stays high. In modes 2 and 3, `play_en` and `restart` stay low until a trigger is accepted.
- R2: Mode encoding on `mode`: 0 is free-running, 1 is retrigger, 2 is armed single start, 3 is armed retrigger.
- R3: In mode 0, every trigger is ignored. `trig_out` stays low, no `restart` occurs, and `play_en` stays high.
- R4: A trigger event is any cycle in which `man_trig` is high, or an edge on `ext_trig`. With `ext_pol`=1 the edge is rising; with `ext_pol`=0 it is falling. If `ext_trig` changes during cycle C, the edge is seen only in cycle C+2, for one cycle. The opposite edge is not a trigger.
- R5: `trig_out` is high in exactly the cycles in which a trigger is accepted. It is combinational with the trigger event.
- R6: With `delay_chips`=0, an accepted trigger in cycle T gives `restart` high for one cycle in T+1, with `play_en` high.
- R7: With `delay_chips`=D>0, an accepted trigger in cycle T holds `play_en` low in cycles T+1 to T+D. `restart` and `play_en` then rise in T+D+1.
- R8: A trigger that arrives while a delay countdown is running is ignored.
- R9: In modes 1 and 3, with `inhibit_chips`=N, triggers in the N cycles after an accepted trigger are ignored. A trigger N+1 cycles later is accepted.
- R10: In mode 2, the first trigger starts playback. Playback then runs freely, and every later trigger is ignored.
- R11: In mode 3, the first trigger starts playback, and each later accepted trigger restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_trig | input | 1 | External trigger line (asynchronous) |
| ext_pol | input | 1 | Active edge select: 1 rising, 0 falling |
| man_trig | input | 1 | Manual trigger strobe |
| mode | input | 2 | Playback mode (see R2) |
| delay_chips | input | 16 | Trigger-to-start delay in chips |
| inhibit_chips | input | 16 | Retrigger lockout in chips |
| play_en | output | 1 | Sequence playback enable |
| restart | output | 1 | One-cycle sequence restart strobe |
| trig_out | output | 1 | Accepted-trigger pulse |

## Verification
The assertions check four rules on every cycle: free-running and post-start single-shot modes never accept a trigger, nothing is accepted during a delay countdown or inside an inhibit window, a zero delay gives a restart on the next cycle, and a restart always comes with playback enabled. The exact cycle counts depend on the delay and inhibit values, so only the bench scenarios can show them. The bench sweeps both values over small ranges and checks the start cycle, the first accepted retrigger, the synchronizer latency and the polarity handling.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [1:0] {
        MODE_FREE       = 2'd0,
        MODE_RETRIG     = 2'd1,
        MODE_ARM_ONCE   = 2'd2,
        MODE_ARM_RETRIG = 2'd3
    } play_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e state;
        logic       restart;
    } ctl_regs_t;

endpackage

// File: rtl/ptc_trig_edge.sv
module ptc_trig_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic pol,
    output logic edge_hit
);
    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    always_comb begin
        if (pol) edge_hit = chain_q[STAGES-1] & ~chain_q[STAGES];
        else     edge_hit = ~chain_q[STAGES-1] & chain_q[STAGES];
    end

endmodule

// File: rtl/ptc_chip_count.sv
module ptc_chip_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         is_zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                    cnt_d = load_val;
        else if (dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt     = cnt_q;
    assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/playback_trigger_ctrl.sv
module playback_trigger_ctrl
    import ptc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_trig,
    input  logic             ext_pol,
    input  logic             man_trig,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] delay_chips,
    input  logic [CNT_W-1:0] inhibit_chips,
    output logic             play_en,
    output logic             restart,
    output logic             trig_out
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    play_mode_e       mode_e;
    ctl_regs_t        regs_d, regs_q;
    logic             ext_hit, trig_evt, accept, can_retrig;
    logic             dly_load, dly_dec, dly_zero, inh_zero;
    logic [CNT_W-1:0] dly_cnt, inh_cnt;

    assign mode_e = play_mode_e'(mode);

    ptc_trig_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(ext_trig), .pol(ext_pol), .edge_hit(ext_hit)
    );

    ptc_chip_count #(.W(CNT_W)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(delay_chips - ONE),
        .dec(dly_dec), .cnt(dly_cnt), .is_zero(dly_zero)
    );

    ptc_chip_count #(.W(CNT_W)) u_inhibit (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_val(inhibit_chips),
        .dec(1'b1), .cnt(inh_cnt), .is_zero(inh_zero)
    );

    assign trig_evt   = ext_hit | man_trig;
    assign can_retrig = (mode_e == MODE_RETRIG) || (mode_e == MODE_ARM_RETRIG);

    always_comb begin
        regs_d         = regs_q;
        regs_d.restart = 1'b0;
        accept         = 1'b0;
        case (regs_q.state)
            ST_IDLE: begin
                if (mode_e == MODE_FREE || mode_e == MODE_RETRIG) begin
                    regs_d.state   = ST_RUN;
                    regs_d.restart = 1'b1;
                end else if (trig_evt) begin
                    accept = 1'b1;
                end
            end
            ST_WAIT: begin
                if (dly_zero) begin
                    regs_d.state   = ST_RUN;
                    regs_d.restart = 1'b1;
                end
            end
            ST_RUN: begin
                if (can_retrig && trig_evt && inh_zero) accept = 1'b1;
            end
            default: regs_d.state = ST_IDLE;
        endcase
        if (accept) begin
            if (delay_chips == '0) begin
                regs_d.state   = ST_RUN;
                regs_d.restart = 1'b1;
            end else begin
                regs_d.state = ST_WAIT;
            end
        end
    end

    assign dly_load = accept && (delay_chips != '0);
    assign dly_dec  = (regs_q.state == ST_WAIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{state: ST_IDLE, restart: 1'b0};
        else        regs_q <= regs_d;
    end

    assign play_en  = (regs_q.state == ST_RUN);
    assign restart  = regs_q.restart;
    assign trig_out = accept;

    assert_quiet_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_FREE) |-> !trig_out);
    assert_hold_in_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_WAIT) |-> !trig_out);
    assert_inhibit_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_cnt != '0) |-> !trig_out);
    assert_zero_delay_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && delay_chips == '0) |=> (restart && play_en));
    assert_delay_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && delay_chips != '0) |=> (!play_en && dly_cnt == $past(delay_chips) - ONE));
    assert_restart_plays_R1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> play_en);
    assert_once_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_ARM_ONCE && play_en) |-> !trig_out);

endmodule

// File: tb/sim_playback_trigger_ctrl.sv
module sim_playback_trigger_ctrl;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_trig = 1'b0, ext_pol = 1'b1, man_trig = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] delay_chips = '0, inhibit_chips = '0;
    logic        play_en, restart, trig_out;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    playback_trigger_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .ext_pol(ext_pol),
        .man_trig(man_trig), .mode(mode), .delay_chips(delay_chips),
        .inhibit_chips(inhibit_chips), .play_en(play_en), .restart(restart),
        .trig_out(trig_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic expect_out(input string req, input int pe, input int rs, input int to);
        #1;
        chk(play_en == pe, {req, " play_en"}, play_en, pe);
        chk(restart == rs, {req, " restart"}, restart, rs);
        chk(trig_out == to, {req, " trig_out"}, trig_out, to);
    endtask

    // advance to 2 time units after the next rising edge
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_n = 1'b0; man_trig = 1'b0; ext_trig = 1'b0; ext_pol = 1'b1; mode = m;
        repeat (3) cyc();
        rst_n = 1'b1;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1, R2 mode 1 start-up, then delay sweep R6 R7 R8
        for (int d = 0; d <= 5; d++) begin
            delay_chips = 16'(d); inhibit_chips = '0;
            do_reset(2'd1);
            expect_out("R1 reset", 0, 0, 0);
            cyc(); expect_out("R1 start", 1, 1, 0);
            cyc(); expect_out("R1 run", 1, 0, 0);
            cyc(); man_trig = 1'b1; expect_out("R5 accept", 1, 0, 1);
            for (int k = 1; k <= d + 2; k++) begin
                cyc();
                man_trig = (k == 1 && d >= 2);
                if (d == 0) expect_out("R6 zero delay", 1, (k == 1) ? 1 : 0, 0);
                else expect_out("R7 R8 delay", (k > d) ? 1 : 0, (k == d + 1) ? 1 : 0, 0);
            end
            man_trig = 1'b0;
        end

        // R9 R11 inhibit sweep in mode 3, zero delay
        for (int n = 0; n <= 5; n++) begin
            delay_chips = '0; inhibit_chips = 16'(n);
            do_reset(2'd3);
            cyc(); expect_out("R1 armed idle", 0, 0, 0);
            cyc(); expect_out("R1 armed idle", 0, 0, 0);
            man_trig = 1'b1; expect_out("R11 first", 0, 0, 1);
            for (int k = 1; k <= n + 1; k++) begin
                cyc();
                expect_out("R9 inhibit", 1, (k == 1) ? 1 : 0, (k == n + 1) ? 1 : 0);
            end
            cyc(); man_trig = 1'b0;
            expect_out("R11 restart", 1, 1, 0);
        end

        // R3 free-running mode ignores both sources
        delay_chips = '0; inhibit_chips = '0;
        do_reset(2'd0);
        cyc(); expect_out("R3 start", 1, 1, 0);
        for (int k = 0; k < 8; k++) begin
            cyc(); man_trig = k[0]; ext_trig = k[1];
            expect_out("R3 ignore", 1, 0, 0);
        end
        man_trig = 1'b0; ext_trig = 1'b0;

        // R10 armed single start with delay 2
        delay_chips = 16'd2;
        do_reset(2'd2);
        cyc(); expect_out("R10 idle", 0, 0, 0);
        man_trig = 1'b1; expect_out("R10 first", 0, 0, 1);
        cyc(); man_trig = 1'b0; expect_out("R10 wait", 0, 0, 0);
        cyc(); expect_out("R10 wait", 0, 0, 0);
        cyc(); expect_out("R10 start", 1, 1, 0);
        for (int k = 0; k < 6; k++) begin
            cyc(); man_trig = 1'b1;
            expect_out("R10 ignore", 1, 0, 0);
        end
        man_trig = 1'b0;

        // R4 external edge latency and polarity, mode 1
        delay_chips = '0; inhibit_chips = '0;
        do_reset(2'd1);
        repeat (3) cyc();
        ext_trig = 1'b1; expect_out("R4 rise c0", 1, 0, 0);
        cyc(); expect_out("R4 rise c1", 1, 0, 0);
        cyc(); expect_out("R4 rise c2", 1, 0, 1);
        cyc(); expect_out("R4 rise c3", 1, 1, 0);
        ext_trig = 1'b0;
        for (int k = 0; k < 4; k++) begin
            cyc(); expect_out("R4 fall ignored", 1, 0, 0);
        end
        ext_pol = 1'b0;
        cyc(); ext_trig = 1'b1;
        for (int k = 0; k < 3; k++) begin
            cyc(); expect_out("R4 rise ignored", 1, 0, 0);
        end
        ext_trig = 1'b0; expect_out("R4 fall c0", 1, 0, 0);
        cyc(); expect_out("R4 fall c1", 1, 0, 0);
        cyc(); expect_out("R4 fall c2", 1, 0, 1);
        cyc(); expect_out("R4 fall c3", 1, 1, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule